// File: doc/BRIEF.md
# Early-Terminating Multiply-Accumulate Unit

This block multiplies two 32-bit integers and returns the low 32 bits of the product. An optional accumulate mode adds a third 32-bit operand to that product. The multiplier operand is consumed one 8-bit slice per internal cycle. The unit stops as soon as the slices still unprocessed are pure sign extension, so the latency depends on the data. A sequencer pulses `start` with the operands. It then waits for `done` and takes the result, along with the condition flags and their write-enables, in that same cycle.

The span check sees the multiplier as two's complement. When the unconsumed upper bits are all ones, the last pass subtracts the multiplicand shifted past the consumed slices. Because of this, the truncated result always equals the low 32 bits of the full product, whether that product is signed or unsigned.

Top module: `mac_et_top`

## Requirements
- R1: With `acc_en` low at start, `result` in the `done` cycle equals (`op_mcand` × `op_mplier`) mod 2^32, for any bit patterns of either operand.
- R2: With `acc_en` high at start, `result` in the `done` cycle equals (`op_mcand` × `op_mplier` + `op_addend`) mod 2^32.
- R3: The pass count P is 1 when multiplier bits 31..8 are all equal, otherwise 2 when bits 31..16 are all equal, otherwise 3 when bits 31..24 are all equal, otherwise 4. In plain mode `done` is high in the cycle following the P-th rising edge after the edge that sampled `start`.
- R4: Accumulate mode makes `done` arrive exactly one cycle later than plain mode does for the same multiplier.
- R5: After reset, `busy`, `done` and all flag write-enables are low. `busy` is high from the edge that accepts `start` until the edge that raises `done`. `done` lasts one cycle, and `busy` is low during it.
- R6: A `start` pulse that arrives while `busy` is high is ignored. The result and the latency of the running operation stay unchanged.
- R7: `we_nz` and `we_c` are high only in the `done` cycle, and only when `set_flags` was high at start. Otherwise they stay low.
- R8: When `we_nz` is high, `flag_n` equals bit 31 of `result`, and `flag_z` is 1 exactly when `result` is zero.
- R9: `we_c` is asserted together with `we_nz`, and `flag_c` then carries a value with no meaning. `we_v` is never asserted.
- R10: All operands and mode inputs are captured at the accepting edge. Later changes on those inputs do not affect the running operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (accepted when not busy) |
| acc_en | input | 1 | Add `op_addend` to the product |
| set_flags | input | 1 | Produce flag write-enables at completion |
| op_mcand | input | 32 | Multiplicand |
| op_mplier | input | 32 | Multiplier; its value sets the pass count |
| op_addend | input | 32 | Addend for accumulate mode |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| result | output | 32 | Low 32 bits of the result, valid with `done` |
| flag_n | output | 1 | Negative flag value |
| flag_z | output | 1 | Zero flag value |
| flag_c | output | 1 | Carry flag value (no meaning, driven 0) |
| flag_v | output | 1 | Overflow flag value (never written) |
| we_nz | output | 1 | Write-enable for N and Z |
| we_c | output | 1 | Write-enable for C |
| we_v | output | 1 | Write-enable for V (always low) |

## Verification
The bench targets the boundary of each span: multipliers whose upper bits are all zeros, and others whose upper bits are all ones, at each of the three early-exit points. A wrong span decoder would show up as the wrong cycle count. A missing tail correction would give wrong products for negative short multipliers. A product that wraps exactly to zero checks that Z comes from the truncated result and not from a wider sum. The bench drives `start` with different operands mid-operation, and it scrambles the inputs right after acceptance. A design that re-latches its operands would return a corrupted result or restart its count.

// File: rtl/mac_et_pkg.sv
package mac_et_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_MUL  = 2'd1,
      ST_ADD  = 2'd2
   } mac_st_e;
endpackage

// File: rtl/mac_et_span.sv
// Finds the last slice index that must be processed: the smallest k whose
// upper bits [W-1 : k*S] are uniform, minus one. Also reports whether the
// skipped tail is all ones (needs a correction term).
module mac_et_span #(
   parameter int DATA_W  = 32,
   parameter int SLICE_W = 8,
   parameter int PASSES  = DATA_W / SLICE_W,
   parameter int CNT_W   = 2
) (
   input  logic [DATA_W-1:0] mplier,
   output logic [CNT_W-1:0]  last_idx,
   output logic              tail_neg
);
   logic [PASSES-1:1] uni;

   for (genvar k = 1; k < PASSES; k++) begin : g_uni
      assign uni[k] = (&mplier[DATA_W-1:k*SLICE_W]) | ~(|mplier[DATA_W-1:k*SLICE_W]);
   end

   always_comb begin
      last_idx = CNT_W'(PASSES - 1);
      for (int k = PASSES - 1; k >= 1; k--) begin
         if (uni[k]) last_idx = CNT_W'(k - 1);
      end
   end

   assign tail_neg = mplier[DATA_W-1] & (last_idx != CNT_W'(PASSES - 1));
endmodule

// File: rtl/mac_et_array.sv
// One pass of the array: multiplicand times the selected multiplier slice,
// placed at the slice weight, minus the sign-tail correction on the last pass.
module mac_et_array #(
   parameter int DATA_W  = 32,
   parameter int SLICE_W = 8,
   parameter int PASSES  = DATA_W / SLICE_W,
   parameter int CNT_W   = 2
) (
   input  logic [DATA_W-1:0] mcand,
   input  logic [DATA_W-1:0] mplier,
   input  logic [CNT_W-1:0]  idx,
   input  logic              last,
   input  logic              tail_neg,
   output logic [DATA_W-1:0] partial
);
   localparam int WIDE_W = DATA_W + SLICE_W;

   logic [SLICE_W-1:0] slc  [PASSES];
   logic [DATA_W-1:0]  plac [PASSES];
   logic [DATA_W-1:0]  corr [PASSES];
   logic [WIDE_W-1:0]  prod_w;
   logic [DATA_W-1:0]  prod_lo;

   for (genvar g = 0; g < PASSES; g++) begin : g_slice
      assign slc[g]  = mplier[g*SLICE_W +: SLICE_W];
      assign plac[g] = prod_lo << (g * SLICE_W);
      if (g + 1 < PASSES) begin : g_corr
         assign corr[g] = mcand << ((g + 1) * SLICE_W);
      end else begin : g_nocorr
         assign corr[g] = '0;
      end
   end

   assign prod_w  = {{SLICE_W{1'b0}}, mcand} * {{DATA_W{1'b0}}, slc[idx]};
   assign prod_lo = prod_w[DATA_W-1:0];
   assign partial = plac[idx] - ((last & tail_neg) ? corr[idx] : '0);
endmodule

// File: rtl/mac_et_flags.sv
module mac_et_flags #(
   parameter int DATA_W = 32
) (
   input  logic [DATA_W-1:0] value,
   output logic              neg,
   output logic              zero,
   output logic              carry
);
   assign neg   = value[DATA_W-1];
   assign zero  = ~(|value);
   assign carry = 1'b0;
endmodule

// File: rtl/mac_et_top.sv
module mac_et_top
   import mac_et_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int SLICE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              acc_en,
   input  logic              set_flags,
   input  logic [DATA_W-1:0] op_mcand,
   input  logic [DATA_W-1:0] op_mplier,
   input  logic [DATA_W-1:0] op_addend,
   output logic              busy,
   output logic              done,
   output logic [DATA_W-1:0] result,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic              we_nz,
   output logic              we_c,
   output logic              we_v
);
   localparam int PASSES = DATA_W / SLICE_W;
   localparam int CNT_W  = (PASSES > 2) ? $clog2(PASSES) : 1;

   if (DATA_W % SLICE_W != 0) begin : g_bad_ratio
      $error("DATA_W must be a multiple of SLICE_W");
   end
   if (PASSES < 2) begin : g_bad_passes
      $error("at least two slices are required");
   end

   mac_st_e           st;
   logic [CNT_W-1:0]  cnt, last_q, last_d;
   logic              tail_q, tail_d;
   logic [DATA_W-1:0] mcand_q, mplier_q, addend_q, acc_q;
   logic              doacc_q, sf_q, done_q, we_q, n_q, z_q;
   logic [DATA_W-1:0] partial, addin, sum_d;
   logic              n_d, z_d, c_d;

   mac_et_span #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .PASSES(PASSES), .CNT_W(CNT_W)) u_span (
      .mplier   (op_mplier),
      .last_idx (last_d),
      .tail_neg (tail_d)
   );

   mac_et_array #(.DATA_W(DATA_W), .SLICE_W(SLICE_W), .PASSES(PASSES), .CNT_W(CNT_W)) u_array (
      .mcand    (mcand_q),
      .mplier   (mplier_q),
      .idx      (cnt),
      .last     (cnt == last_q),
      .tail_neg (tail_q),
      .partial  (partial)
   );

   assign addin = (st == ST_ADD) ? addend_q : partial;
   assign sum_d = acc_q + addin;

   mac_et_flags #(.DATA_W(DATA_W)) u_flags (
      .value (sum_d),
      .neg   (n_d),
      .zero  (z_d),
      .carry (c_d)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= ST_IDLE;
         cnt      <= '0;
         last_q   <= '0;
         tail_q   <= 1'b0;
         mcand_q  <= '0;
         mplier_q <= '0;
         addend_q <= '0;
         acc_q    <= '0;
         doacc_q  <= 1'b0;
         sf_q     <= 1'b0;
         done_q   <= 1'b0;
         we_q     <= 1'b0;
         n_q      <= 1'b0;
         z_q      <= 1'b0;
      end else begin
         done_q <= 1'b0;
         we_q   <= 1'b0;
         unique case (st)
            ST_IDLE: begin
               if (start) begin
                  mcand_q  <= op_mcand;
                  mplier_q <= op_mplier;
                  addend_q <= op_addend;
                  doacc_q  <= acc_en;
                  sf_q     <= set_flags;
                  last_q   <= last_d;
                  tail_q   <= tail_d;
                  acc_q    <= '0;
                  cnt      <= '0;
                  st       <= ST_MUL;
               end
            end
            ST_MUL: begin
               acc_q <= sum_d;
               if (cnt == last_q) begin
                  if (doacc_q) begin
                     st <= ST_ADD;
                  end else begin
                     st     <= ST_IDLE;
                     done_q <= 1'b1;
                     we_q   <= sf_q;
                     n_q    <= n_d;
                     z_q    <= z_d;
                  end
               end else begin
                  cnt <= cnt + 1'b1;
               end
            end
            ST_ADD: begin
               acc_q  <= sum_d;
               st     <= ST_IDLE;
               done_q <= 1'b1;
               we_q   <= sf_q;
               n_q    <= n_d;
               z_q    <= z_d;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy   = (st != ST_IDLE);
   assign done   = done_q;
   assign result = acc_q;
   assign flag_n = n_q;
   assign flag_z = z_q;
   assign flag_c = c_d;
   assign flag_v = 1'b0;
   assign we_nz  = we_q;
   assign we_c   = we_q;
   assign we_v   = 1'b0;
endmodule

// File: rtl/mac_et_chk.sv
module mac_et_chk #(
   parameter int DATA_W  = 32,
   parameter int SLICE_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              start,
   input logic              busy,
   input logic              done,
   input logic              we_nz,
   input logic              we_c,
   input logic              flag_n,
   input logic              flag_z,
   input logic [DATA_W-1:0] result,
   input logic [DATA_W-1:0] lat_mcand
);
   localparam int PASSES = DATA_W / SLICE_W;
   localparam int LCW    = $clog2(PASSES + 2) + 1;

   logic [LCW-1:0] bcnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    bcnt <= '0;
      else if (busy) bcnt <= bcnt + 1'b1;
      else           bcnt <= '0;
   end

   p_done_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   p_done_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
   p_busy_needs_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));
   p_start_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && start) |=> $stable(lat_mcand));
   p_we_in_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (we_nz || we_c) |-> done);
   p_neg_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we_nz |-> (flag_n == result[DATA_W-1]));
   p_zero_res_r8: assert property (@(posedge clk) disable iff (!rst_n)
      we_nz |-> (flag_z == (result == '0)));
   p_latency_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (bcnt >= LCW'(1) && bcnt <= LCW'(PASSES + 1)));
endmodule

bind mac_et_top mac_et_chk #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .busy      (busy),
   .done      (done),
   .we_nz     (we_nz),
   .we_c      (we_c),
   .flag_n    (flag_n),
   .flag_z    (flag_z),
   .result    (result),
   .lat_mcand (mcand_q)
);

// File: tb/sim_mac_et_top.sv
`timescale 1ns/1ps
module sim_mac_et_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        acc_en = 1'b0;
   logic        set_flags = 1'b0;
   logic [31:0] op_mcand = '0;
   logic [31:0] op_mplier = '0;
   logic [31:0] op_addend = '0;
   logic        busy, done, flag_n, flag_z, flag_c, flag_v, we_nz, we_c, we_v;
   logic [31:0] result;

   int n_chk = 0;
   int n_bad = 0;
   bit finished = 1'b0;

   always #2 clk = ~clk;

   mac_et_top u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .acc_en(acc_en), .set_flags(set_flags),
      .op_mcand(op_mcand), .op_mplier(op_mplier), .op_addend(op_addend),
      .busy(busy), .done(done), .result(result),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
      .we_nz(we_nz), .we_c(we_c), .we_v(we_v)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   function automatic int exp_passes(input logic [31:0] b);
      for (int k = 1; k < 4; k++) begin
         int s;
         s = $signed(b) >>> (k * 8);
         if (s == 0 || s == -1) return k;
      end
      return 4;
   endfunction

   // One complete operation; poke drives a stray start while busy (R6).
   task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c,
                         input bit acc, input bit sf, input bit poke);
      logic [63:0] full;
      logic [31:0] exp;
      int lat;
      int want;
      bit busy_ok;
      full = {32'd0, a} * {32'd0, b};
      exp  = full[31:0] + (acc ? c : 32'd0);
      want = exp_passes(b) + (acc ? 1 : 0);
      @(negedge clk);
      op_mcand = a; op_mplier = b; op_addend = c; acc_en = acc; set_flags = sf; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      // R10: scramble inputs after acceptance
      op_mcand = ~a; op_mplier = ~b; op_addend = ~c; acc_en = ~acc; set_flags = ~sf;
      lat = 0;
      busy_ok = 1'b1;
      while (!done && lat < 20) begin
         if (!busy) busy_ok = 1'b0;
         if (poke && lat == 0) start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         lat++;
      end
      chk(busy_ok, "R5", "busy held until done", {31'd0, busy_ok}, 32'd1);
      chk(lat == want, acc ? "R4" : "R3", "latency", lat, want);
      chk(result == exp, acc ? "R2" : "R1", "result", result, exp);
      chk(!busy, "R5", "busy low in done cycle", {31'd0, busy}, 32'd0);
      if (sf) begin
         chk(we_nz && flag_n == exp[31] && flag_z == (exp == 32'd0), "R8", "N/Z",
             {29'd0, we_nz, flag_n, flag_z}, {29'd0, 1'b1, exp[31], exp == 32'd0});
         chk(we_c, "R9", "C write-enable", {31'd0, we_c}, 32'd1);
      end else begin
         chk(!we_nz && !we_c, "R7", "no flag write", {30'd0, we_nz, we_c}, 32'd0);
      end
      chk(!we_v, "R9", "V write-enable", {31'd0, we_v}, 32'd0);
      @(negedge clk);
      chk(!done && !we_nz, "R5", "done one cycle", {30'd0, done, we_nz}, 32'd0);
   endtask

   task automatic test_reset;
      chk(!busy && !done, "R5", "reset busy/done", {30'd0, busy, done}, 32'd0);
      chk(!we_nz && !we_c && !we_v, "R5", "reset write-enables", {29'd0, we_nz, we_c, we_v}, 32'd0);
   endtask

   task automatic test_spans_plain;   // R1, R3
      run_op(32'h0000_1234, 32'h0000_0005, 32'h0, 1'b0, 1'b0, 1'b0);
      run_op(32'h0000_0021, 32'hFFFF_FF80, 32'h0, 1'b0, 1'b1, 1'b0);
      run_op(32'h0001_0003, 32'h0000_1234, 32'h0, 1'b0, 1'b0, 1'b0);
      run_op(32'hDEAD_BEEF, 32'hFFFF_8001, 32'h0, 1'b0, 1'b1, 1'b0);
      run_op(32'h0765_4321, 32'h0012_3456, 32'h0, 1'b0, 1'b0, 1'b0);
      run_op(32'h8000_0001, 32'hFF80_0000, 32'h0, 1'b0, 1'b1, 1'b0);
      run_op(32'h1357_9BDF, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b0);
      run_op(32'hFFFF_FFFF, 32'h8000_0000, 32'h0, 1'b0, 1'b1, 1'b0);
      run_op(32'hCAFE_F00D, 32'h7FFF_FFFF, 32'h0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_accum;         // R2, R4
      run_op(32'h0000_1234, 32'h0000_0005, 32'h1111_1111, 1'b1, 1'b0, 1'b0);
      run_op(32'hDEAD_BEEF, 32'hFFFF_8001, 32'hFFFF_FFFF, 1'b1, 1'b1, 1'b0);
      run_op(32'h1357_9BDF, 32'h1234_5678, 32'h8765_4321, 1'b1, 1'b0, 1'b0);
   endtask

   task automatic test_flags;         // R8, R9
      run_op(32'h0001_0000, 32'h0001_0000, 32'h0, 1'b0, 1'b1, 1'b0);   // wraps to zero
      run_op(32'h0000_0003, 32'hFFFF_FFFF, 32'h0, 1'b0, 1'b1, 1'b0);   // negative
      run_op(32'h0000_0002, 32'h0000_0003, 32'hFFFF_FFFA, 1'b1, 1'b1, 1'b0); // sum zero
   endtask

   task automatic test_no_flags;      // R7
      run_op(32'h0000_0000, 32'h1234_5678, 32'h0, 1'b0, 1'b0, 1'b0);
   endtask

   task automatic test_ignore_start;  // R6
      run_op(32'h0000_0077, 32'h0000_0009, 32'h0, 1'b0, 1'b1, 1'b1);
      run_op(32'h0BAD_F00D, 32'h89AB_CDEF, 32'h0000_0042, 1'b1, 1'b1, 1'b1);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      test_reset();
      rst_n = 1'b1;
      @(negedge clk);
      test_reset();
      test_spans_plain();
      test_accum();
      test_flags();
      test_no_flags();
      test_ignore_start();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      #(4 * 100000);
      if (!finished) begin
         finished = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end
endmodule